// File: doc/BRIEF.md
# Windowed Watchdog with Token Handshake

This block supervises software through two back-to-back timing windows. After each start or restart it first runs a closed window, during which any restart attempt counts as misbehaviour. It then runs an open window, during which software must service it. If the open window runs out with no service, the block raises a timeout and asks for a system reset. Both window lengths are held in 32-bit registers.

In basic mode a single restart write during the open window services the watchdog. In token mode software must prove it is working correctly. It writes three correct one-byte answers while the window is closed and one more correct answer once it is open. Each answer is derived from a seed, a tap mask and a running answer count. Any wrong byte, a surplus write or a missing answer is a bad event. The block restarts its window pair after every bad event, so supervision continues.

Software programs the block through a write-only register port. The service and answer bytes arrive on a separate strobe.

Top module: `window_guard`

## Requirements
- R1: After reset, `bad_irq`, `rst_req` and `timeout_seen` are 0 and the block is idle. While it is idle, writes on the service strobe have no effect.
- R2: A write to address 0 with bit 0 set (enable) starts a closed window lasting N cycles, where N is the value at address 1. A value of 0 counts as 1 cycle. Bit 1 of the same write selects token mode (1) or basic mode (0). Any write to address 0 also restarts the window pair.
- R3: When the closed window ends, an open window begins that lasts M cycles, where M is the value at address 2 (0 counts as 1). With the default lengths of 5 and 4 and no service, the reset pulse follows the restart by 9 cycles.
- R4: In basic mode, a service write during the open window starts a new closed window and raises no event.
- R5: In basic mode, a service write during the closed window sets `bad_irq` and restarts the closed window.
- R6: If the open window expires without valid service, `rst_req` pulses for exactly one cycle, `timeout_seen` and `bad_irq` are set, and a new closed window begins.
- R7: In token mode the expected answer for count k (k = 0..3) is L(k+1) XOR k. Here L(0) is the seed byte at address 3, bits 7:0. L(i+1) is L(i) shifted left by one, with the parity of (L(i) AND tap mask) entering bit 0. The tap mask is at address 3, bits 15:8. The count and L restart from 0 and the seed at every window restart.
- R8: In token mode, three correct answers in the closed window followed by a correct fourth answer in the open window restart the pair with no event.
- R9: In token mode, a wrong answer byte in either window sets `bad_irq` and restarts the pair.
- R10: In token mode, a fourth write during the closed window is a bad event.
- R11: In token mode, if the closed window ends with fewer than three correct answers, `bad_irq` is set and a new closed window starts instead of the open window.
- R12: A write to address 0 with bit 0 clear returns the block to idle at once with no event. While the block is idle, no event can occur.
- R13: A write to address 4 clears `timeout_seen` if bit 0 is 1 and clears `bad_irq` if bit 1 is 1. An event in the same cycle wins over the clear. Otherwise both flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (3) | Register address |
| reg_wdata | input | DW (32) | Register write data |
| kick_we | input | 1 | Service / answer write strobe |
| kick_byte | input | 8 | Service / answer byte |
| bad_irq | output | 1 | Sticky bad-event interrupt |
| rst_req | output | 1 | One-cycle reset request on timeout |
| timeout_seen | output | 1 | Sticky timeout status |

## Verification
The bench aims at the window edges. A service write on the last closed cycle or the first open cycle separates a design whose window is one cycle off from a correct one. Zero-length windows catch a counter that wraps instead of treating 0 as one cycle. In token mode, an answer sent without the count XOR, a fourth closed-window answer and a window that ends after only two answers each exposes a different shortcut in the answer logic. A design that skipped the check, allowed the surplus write or missed the shortfall would leave `bad_irq` low. Disabling the block in the middle of a window shows whether a stale counter can still fire a reset.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int TOK_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CLOSED = 2'd1,
    ST_OPEN   = 2'd2
  } win_st_e;

  localparam int A_CTRL  = 0;
  localparam int A_CLEN  = 1;
  localparam int A_OLEN  = 2;
  localparam int A_TOKEN = 3;
  localparam int A_CLEAR = 4;

  // One shift of the answer generator: feedback is the parity of the tapped bits.
  function automatic logic [TOK_W-1:0] lfsr_step(input logic [TOK_W-1:0] v,
                                                 input logic [TOK_W-1:0] taps);
    return {v[TOK_W-2:0], ^(v & taps)};
  endfunction
endpackage

// File: rtl/wg_regs.sv
module wg_regs
  import wg_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 3,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic             qa,
  output logic [CNT_W-1:0] len_c,
  output logic [CNT_W-1:0] len_o,
  output logic [TOK_W-1:0] seed,
  output logic [TOK_W-1:0] taps,
  output logic             ctrl_start,
  output logic             ctrl_stop,
  output logic             clr_to,
  output logic             clr_bad
);
  localparam int TOK_HI = 2 * TOK_W;

  logic hit_ctrl, hit_clen, hit_olen, hit_tok, hit_clr;
  logic qa_d;
  logic [CNT_W-1:0] len_c_d, len_o_d;
  logic [TOK_W-1:0] seed_d, taps_d;
  logic unused_hi;

  assign unused_hi = ^wdata[DW-1:TOK_HI];

  always_comb begin
    hit_ctrl = we && (addr == AW'(A_CTRL));
    hit_clen = we && (addr == AW'(A_CLEN));
    hit_olen = we && (addr == AW'(A_OLEN));
    hit_tok  = we && (addr == AW'(A_TOKEN));
    hit_clr  = we && (addr == AW'(A_CLEAR));
    qa_d     = hit_ctrl ? wdata[1] : qa;
    len_c_d  = hit_clen ? wdata[CNT_W-1:0] : len_c;
    len_o_d  = hit_olen ? wdata[CNT_W-1:0] : len_o;
    seed_d   = hit_tok  ? wdata[TOK_W-1:0] : seed;
    taps_d   = hit_tok  ? wdata[TOK_HI-1:TOK_W] : taps;
  end

  assign ctrl_start = hit_ctrl &  wdata[0];
  assign ctrl_stop  = hit_ctrl & ~wdata[0];
  assign clr_to     = hit_clr  &  wdata[0];
  assign clr_bad    = hit_clr  &  wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qa    <= 1'b0;
      len_c <= CNT_W'(5);
      len_o <= CNT_W'(4);
      seed  <= '0;
      taps  <= '0;
    end else begin
      if (hit_ctrl) qa    <= qa_d;
      if (hit_clen) len_c <= len_c_d;
      if (hit_olen) len_o <= len_o_d;
      if (hit_tok) begin
        seed <= seed_d;
        taps <= taps_d;
      end
    end
  end
endmodule

// File: rtl/wg_timer.sv
module wg_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  input  logic             run,
  output logic             zero
);
  logic [CNT_W-1:0] cnt, cnt_d;
  logic upd;

  always_comb begin
    upd   = load | (run & (cnt != '0));
    cnt_d = cnt;
    if (load)     cnt_d = (len == '0) ? '0 : len - CNT_W'(1);
    else if (upd) cnt_d = cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (upd) cnt <= cnt_d;
  end

  assign zero = (cnt == '0);

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !zero) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/wg_token.sv
module wg_token
  import wg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             accept,
  input  logic [TOK_W-1:0] seed,
  input  logic [TOK_W-1:0] taps,
  output logic [TOK_W-1:0] expect_tok,
  output logic [1:0]       ans
);
  logic [TOK_W-1:0] lfsr, lfsr_d, lfsr_nx;
  logic [1:0] ans_d;
  logic upd;

  always_comb begin
    lfsr_nx    = lfsr_step(lfsr, taps);
    expect_tok = lfsr_nx ^ {{(TOK_W-2){1'b0}}, ans};
    upd        = restart | accept;
    lfsr_d     = restart ? seed : lfsr_nx;
    ans_d      = restart ? 2'd0 : ans + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr <= '0;
      ans  <= 2'd0;
    end else if (upd) begin
      lfsr <= lfsr_d;
      ans  <= ans_d;
    end
  end

  assert_restart_seed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ans == 2'd0) && (lfsr == $past(seed)));
endmodule

// File: rtl/window_guard.sv
module window_guard
  import wg_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 3,
  parameter int CNT_W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          kick_we,
  input  logic [7:0]    kick_byte,
  output logic          bad_irq,
  output logic          rst_req,
  output logic          timeout_seen
);
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic qa, ctrl_start, ctrl_stop, clr_to, clr_bad;
  logic [CNT_W-1:0] len_c, len_o, t_len;
  logic [TOK_W-1:0] seed, taps, tok_exp;
  logic [1:0] tok_ans, ans_nx;
  logic t_load, t_zero, t_run, tok_rst, tok_acc;
  logic ev_bad, ev_to, restart;
  logic bad_d, to_d;
  win_st_e st, st_d;

  wg_regs #(.DW(DW), .AW(AW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .qa(qa), .len_c(len_c), .len_o(len_o), .seed(seed), .taps(taps),
    .ctrl_start(ctrl_start), .ctrl_stop(ctrl_stop), .clr_to(clr_to), .clr_bad(clr_bad));

  wg_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_s), .load(t_load), .len(t_len), .run(t_run), .zero(t_zero));

  wg_token u_token (
    .clk(clk), .rst_n(rst_s), .restart(tok_rst), .accept(tok_acc),
    .seed(seed), .taps(taps), .expect_tok(tok_exp), .ans(tok_ans));

  assign t_run  = (st != ST_IDLE);
  assign ans_nx = tok_ans + 2'd1;

  always_comb begin
    st_d    = st;
    t_load  = 1'b0;
    t_len   = len_c;
    tok_rst = 1'b0;
    tok_acc = 1'b0;
    ev_bad  = 1'b0;
    ev_to   = 1'b0;
    restart = 1'b0;
    if (ctrl_start) begin
      restart = 1'b1;
    end else if (ctrl_stop) begin
      st_d = ST_IDLE;
    end else begin
      case (st)
        ST_CLOSED: begin
          if (kick_we) begin
            if (qa && (tok_ans != 2'd3) && (kick_byte == tok_exp)) begin
              tok_acc = 1'b1;
              if (t_zero) begin
                if (ans_nx == 2'd3) begin
                  st_d   = ST_OPEN;
                  t_load = 1'b1;
                  t_len  = len_o;
                end else begin
                  ev_bad  = 1'b1;
                  restart = 1'b1;
                end
              end
            end else begin
              ev_bad  = 1'b1;
              restart = 1'b1;
            end
          end else if (t_zero) begin
            if (qa && (tok_ans != 2'd3)) begin
              ev_bad  = 1'b1;
              restart = 1'b1;
            end else begin
              st_d   = ST_OPEN;
              t_load = 1'b1;
              t_len  = len_o;
            end
          end
        end
        ST_OPEN: begin
          if (kick_we) begin
            restart = 1'b1;
            if (qa && (kick_byte != tok_exp)) ev_bad = 1'b1;
          end else if (t_zero) begin
            ev_to   = 1'b1;
            restart = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (restart) begin
      st_d    = ST_CLOSED;
      t_load  = 1'b1;
      t_len   = len_c;
      tok_rst = 1'b1;
    end
  end

  always_comb begin
    bad_d = ev_bad | ev_to | (bad_irq & ~clr_bad);
    to_d  = ev_to | (timeout_seen & ~clr_to);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st           <= ST_IDLE;
      bad_irq      <= 1'b0;
      rst_req      <= 1'b0;
      timeout_seen <= 1'b0;
    end else begin
      st           <= st_d;
      bad_irq      <= bad_d;
      rst_req      <= ev_to;
      timeout_seen <= to_d;
    end
  end

  assert_rst_single_R6: assert property (@(posedge clk) disable iff (!rst_s)
    rst_req |=> !rst_req);
  assert_to_flags_R6: assert property (@(posedge clk) disable iff (!rst_s)
    rst_req |-> (timeout_seen && bad_irq));
  assert_open_three_R11: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_OPEN && qa) |-> (tok_ans == 2'd3));
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_IDLE) |=> !rst_req);
  assert_stop_idle_R12: assert property (@(posedge clk) disable iff (!rst_s)
    ctrl_stop |=> (st == ST_IDLE) && !rst_req);
  assert_bad_hold_R13: assert property (@(posedge clk) disable iff (!rst_s)
    (bad_irq && !clr_bad) |=> bad_irq);
endmodule

// File: tb/sim_window_guard.sv
module sim_window_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic kick_we = 1'b0;
  logic [7:0] kick_byte = '0;
  logic bad_irq, rst_req, timeout_seen;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  window_guard u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .kick_we(kick_we), .kick_byte(kick_byte),
    .bad_irq(bad_irq), .rst_req(rst_req), .timeout_seen(timeout_seen));

  function automatic int step8(int v, int t);
    int p = 0;
    for (int i = 0; i < 8; i++) p ^= ((v & t) >> i) & 1;
    return ((v << 1) & 8'hFE) | p;
  endfunction

  // Reference model: 0 idle, 1 closed, 2 open.
  int ms = 0, ma = 0, ml = 0, mcnt = 0;
  int mlc = 5, mlo = 4, mseed = 0, mtaps = 0;
  bit mqa = 0, mbad = 0, mrst = 0, mto = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; ma = 0; ml = 0; mcnt = 0; mlc = 5; mlo = 4; mseed = 0; mtaps = 0;
      mqa = 0; mbad = 0; mrst = 0; mto = 0;
    end else begin
      bit eb, et, rs, cb, ct;
      int ex;
      eb = 0; et = 0; rs = 0;
      ex = step8(ml, mtaps) ^ ma;
      cb = reg_we && reg_addr == 4 && reg_wdata[1];
      ct = reg_we && reg_addr == 4 && reg_wdata[0];
      if (reg_we && reg_addr == 0) begin
        if (reg_wdata[0]) rs = 1; else ms = 0;
      end else if (ms == 1) begin
        if (kick_we) begin
          if (mqa && ma != 3 && int'(kick_byte) == ex) begin
            ml = step8(ml, mtaps); ma++;
            if (mcnt == 0) begin
              if (ma == 3) begin ms = 2; mcnt = (mlo == 0) ? 0 : mlo - 1; end
              else begin eb = 1; rs = 1; end
            end else mcnt--;
          end else begin eb = 1; rs = 1; end
        end else if (mcnt == 0) begin
          if (mqa && ma != 3) begin eb = 1; rs = 1; end
          else begin ms = 2; mcnt = (mlo == 0) ? 0 : mlo - 1; end
        end else mcnt--;
      end else if (ms == 2) begin
        if (kick_we) begin
          rs = 1;
          if (mqa && int'(kick_byte) != ex) eb = 1;
        end else if (mcnt == 0) begin et = 1; rs = 1; end
        else mcnt--;
      end
      if (rs) begin ms = 1; mcnt = (mlc == 0) ? 0 : mlc - 1; ma = 0; ml = mseed; end
      mbad = eb | et | (mbad & !cb);
      mto  = et | (mto & !ct);
      mrst = et;
      if (reg_we) begin
        case (reg_addr)
          3'd0: mqa = reg_wdata[1];
          3'd1: mlc = int'(reg_wdata);
          3'd2: mlo = int'(reg_wdata);
          3'd3: begin mseed = int'(reg_wdata[7:0]); mtaps = int'(reg_wdata[15:8]); end
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && !done) begin
      check(cur_req, "model bad_irq", int'(bad_irq), int'(mbad));
      check(cur_req, "model rst_req", int'(rst_req), int'(mrst));
      check(cur_req, "model timeout_seen", int'(timeout_seen), int'(mto));
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); reg_we = 1; reg_addr = 3'(a); reg_wdata = 32'(d);
    @(negedge clk); reg_we = 0;
  endtask
  task automatic kick(int b);
    @(negedge clk); kick_we = 1; kick_byte = 8'(b);
    @(negedge clk); kick_we = 0;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic wait_open();
    while (ms != 2) @(negedge clk);
  endtask

  int tok[4];
  task automatic make_tokens(int s, int t);
    int l = s;
    for (int k = 0; k < 4; k++) begin l = step8(l, t); tok[k] = l ^ k; end
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    int cnt, first;
    idle(3);
    rst_n = 1;
    idle(4);
    chk_on = 1;
    cur_req = "R1";
    check("R1", "bad_irq after reset", int'(bad_irq), 0);
    check("R1", "rst_req after reset", int'(rst_req), 0);
    check("R1", "timeout_seen after reset", int'(timeout_seen), 0);
    kick(8'h11); idle(20);
    check("R1", "kick while idle", int'(bad_irq | rst_req | timeout_seen), 0);

    cur_req = "R4";
    wr(0, 1); wait_open(); kick(0); idle(2);
    check("R4", "open kick no event", int'(bad_irq), 0);

    cur_req = "R5";
    idle(1); kick(0); idle(1);
    check("R5", "closed kick bad", int'(bad_irq), 1);
    cur_req = "R13";
    wr(4, 2); idle(1);
    check("R13", "bad_irq cleared", int'(bad_irq), 0);

    cur_req = "R3";
    wait_open(); kick(0);
    cnt = 0; first = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (rst_req) begin cnt++; if (first == 0) first = k; end
    end
    check("R3", "cycles to reset pulse", first, 9);
    check("R6", "one reset pulse", cnt, 1);
    check("R6", "timeout_seen set", int'(timeout_seen), 1);
    cur_req = "R13";
    wr(4, 3); idle(1);
    check("R13", "timeout_seen cleared", int'(timeout_seen), 0);

    cur_req = "R2";
    wr(1, 0); wr(2, 0); wr(0, 1);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (rst_req) cnt++; end
    check("R2", "zero-length pulses", cnt, 10);
    cur_req = "R12";
    wr(0, 0); wr(4, 3); idle(40);
    check("R12", "no event when disabled", int'(bad_irq | rst_req | timeout_seen), 0);

    cur_req = "R8";
    make_tokens(8'hA5, 8'hB8);
    wr(1, 20); wr(2, 10); wr(3, 32'h0000_B8A5); wr(0, 3);
    kick(tok[0]); kick(tok[1]); kick(tok[2]); wait_open(); kick(tok[3]); idle(2);
    check("R8", "good token round", int'(bad_irq | rst_req), 0);
    kick(tok[0]); kick(tok[1]); kick(tok[2]); wait_open(); kick(tok[3]); idle(2);
    check("R8", "second good round", int'(bad_irq | rst_req), 0);

    cur_req = "R9";
    kick(tok[0] ^ 8'hFF); idle(1);
    check("R9", "wrong token bad", int'(bad_irq), 1);
    wr(4, 2);
    kick(tok[0]); kick(tok[1]); kick(tok[2]); wait_open(); kick(tok[3] ^ 1); idle(1);
    check("R9", "wrong open token bad", int'(bad_irq), 1);
    wr(4, 2);

    cur_req = "R7";
    kick(tok[0]); kick(tok[1] ^ 1); idle(1);
    check("R7", "count XOR required", int'(bad_irq), 1);
    wr(4, 2);

    cur_req = "R10";
    kick(tok[0]); kick(tok[1]); kick(tok[2]); kick(tok[2]); idle(1);
    check("R10", "fourth closed write bad", int'(bad_irq), 1);
    wr(4, 2);

    cur_req = "R11";
    kick(tok[0]); kick(tok[1]); idle(25);
    check("R11", "short answers bad", int'(bad_irq), 1);
    check("R11", "no timeout on short answers", int'(timeout_seen), 0);

    cur_req = "R12";
    wr(0, 0); wr(4, 3); idle(60);
    check("R12", "idle after disable", int'(bad_irq | rst_req | timeout_seen), 0);
    finish_run();
  end
endmodule